// File: doc/BRIEF.md
# Randomized Shield Rerouting Integrity Checker

This block is the digital controller behind an active shield wire check. A set of shield lines runs over protected logic. Switch arrays at both ends of the lines share one routing code taken from an external random source. Two test streams travel through whichever lines the current code assigns them to. The checker loads a fresh code at regular intervals and drives two mutually exclusive switch phases. Between them it inserts dead time, so the two ends never hold different routings while a change is under way.

Once the switches have settled after each reload, the checker compares every returned stream with the stream that was sent. On an intact shield the two always agree, whatever the code. A line that has been cut, or two neighbouring lines that have been strapped together, makes some codes route different streams onto joined wires. The returned value then differs from the sent one. A mismatch has to last for a run of consecutive samples before it counts, which filters out switching transients. The detect output stays high until software clears it. The check runs only while its enable is set and the companion probe-detection mode is off.

Top module: `shield_reroute_checker`

## Requirements
- R1: While rst_n is low at a clock edge, both phase outputs, tamper_det and route_code (value 0) are all cleared after that edge.
- R2: route_code takes the value present on rand_code only at the edge that raises a phase, and route_code never changes while ph1 or ph2 is high.
- R3: ph1 and ph2 are never high together. At least DEAD_CYC cycles with both low separate any two drive epochs. Epochs alternate ph1, ph2, ph1, and so on, and the first epoch after activation uses ph1.
- R4: After activation there are DEAD_CYC + 1 cycles with both phases low, then the phase stays high for exactly EPOCH_CYC cycles, and then the pattern repeats with a period of DEAD_CYC + EPOCH_CYC.
- R5: Mismatches are ignored in the first SETTLE_CYC cycles of each epoch and at every moment when no phase is high.
- R6: A compare sample is a mismatch when rx_bits differs from tx_bits in any bit position. Bit 0 is stream A and bit 1 is stream B. tamper_det rises at the edge of the MISMATCH_RUN-th consecutive mismatching compare sample. A shorter run has no effect.
- R7: tamper_det stays high until a cycle in which det_clr is high and no new detection occurs. A detection in the same cycle as det_clr wins.
- R8: The check is active only while chk_en is 1 and probe_en is 0, and chk_active shows this state. When the check goes inactive, both phases drop at the next edge and comparison stops. On re-activation the sequence restarts from dead time with ph1.
- R9: An intact shield never raises tamper_det under random codes and streams. Adjacent lines shorted together go undetected while their code bits are equal, and are detected once a code with those bits different is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_en | input | 1 | Request for the wire-check mode |
| probe_en | input | 1 | Probe-detection mode is running; blocks this check |
| det_clr | input | 1 | Synchronous clear of tamper_det |
| rand_code | input | CODE_W | Random routing code from the external source |
| tx_bits | input | STREAMS | Transmitted test streams (bit 0 = A, bit 1 = B) |
| rx_bits | input | STREAMS | Streams returned through the shield |
| route_code | output | CODE_W | Routing code held for both switch arrays |
| ph1 | output | 1 | Switch phase 1 enable |
| ph2 | output | 1 | Switch phase 2 enable |
| tamper_det | output | 1 | Sticky tamper detection |
| chk_active | output | 1 | Check mode is currently active |

## Verification
The bench places one-sample mismatches to test the run filter. A filter that is too short would latch tamper_det on a single transient. It also places mismatches inside the dead time and the settle window, where a design that compares too early would raise a false alarm. A clear issued in the same cycle as a fresh detection is checked. A design where clear takes priority would drop a live tamper. The bench toggles the interlock in the middle of an epoch, which exposes phases left high or a restart on the wrong phase. A modelled short between adjacent lines is first hidden by an equal-bit code and then exposed by a differing one, which shows that the code is really reloaded and that the routing follows it.

// File: rtl/shield_reroute_pkg.sv
// Package: shared types for the shield reroute checker.
// Assumes: nothing beyond a standard SystemVerilog elaborator.
package shield_reroute_pkg;

    // Sequencer states: idle (check off), dead time (both phases low), drive epoch.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_DEAD  = 2'd1,
        SEQ_DRIVE = 2'd2
    } seq_state_t;

endpackage

// File: rtl/shield_route_sequencer.sv
// Module: shield_route_sequencer
// Does: paces the routing code updates. Each period has DEAD_CYC cycles with
// both switch phases low. At the last dead edge it captures a new random code
// and raises the next phase in turn, and it holds that phase for EPOCH_CYC
// cycles. Compares are allowed once SETTLE_CYC cycles of the epoch have passed.
// Assumes: DEAD_CYC >= 1 and SETTLE_CYC < EPOCH_CYC; 'active' is synchronous.
module shield_route_sequencer
    import shield_reroute_pkg::*;
#(
    parameter int CODE_W     = 5,
    parameter int DEAD_CYC   = 2,
    parameter int SETTLE_CYC = 3,
    parameter int EPOCH_CYC  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [CODE_W-1:0] rand_code,
    output logic [CODE_W-1:0] route_code,
    output logic              ph1,
    output logic              ph2,
    output logic              cmp_win
);

    localparam int CNT_MAX = (EPOCH_CYC > DEAD_CYC) ? EPOCH_CYC : DEAD_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] DEAD_LAST  = CNT_W'(DEAD_CYC - 1);
    localparam logic [CNT_W-1:0] EPOCH_LAST = CNT_W'(EPOCH_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_END = CNT_W'(SETTLE_CYC);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             next_p2;

    // Main sequence: idle -> dead time -> load code and drive one phase -> dead time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SEQ_IDLE;
            cnt        <= '0;
            route_code <= '0;
            ph1        <= 1'b0;
            ph2        <= 1'b0;
            next_p2    <= 1'b0;
        end else if (!active) begin
            state   <= SEQ_IDLE;
            cnt     <= '0;
            ph1     <= 1'b0;
            ph2     <= 1'b0;
            next_p2 <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    state <= SEQ_DEAD;
                    cnt   <= '0;
                end
                SEQ_DEAD: begin
                    if (cnt == DEAD_LAST) begin
                        state      <= SEQ_DRIVE;
                        cnt        <= '0;
                        route_code <= rand_code;
                        ph1        <= !next_p2;
                        ph2        <= next_p2;
                        next_p2    <= !next_p2;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                SEQ_DRIVE: begin
                    if (cnt == EPOCH_LAST) begin
                        state <= SEQ_DEAD;
                        cnt   <= '0;
                        ph1   <= 1'b0;
                        ph2   <= 1'b0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: begin
                    state <= SEQ_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Compare window: inside a drive epoch, past the settle time, check still on.
    always_comb begin
        cmp_win = active && (state == SEQ_DRIVE) && (cnt >= SETTLE_END);
    end

endmodule

// File: rtl/shield_mismatch_filter.sv
// Module: shield_mismatch_filter
// Does: compares every returned stream with its sent stream inside the compare
// window. It counts consecutive mismatching samples and latches a sticky
// detect once RUN_LEN of them occur in a row. A detection beats a clear in
// the same cycle.
// Assumes: tx and rx are already aligned to the same clock.
module shield_mismatch_filter #(
    parameter int STREAMS = 2,
    parameter int RUN_LEN = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmp_win,
    input  logic [STREAMS-1:0] tx,
    input  logic [STREAMS-1:0] rx,
    input  logic               clr,
    output logic               det
);

    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_SAT  = RUN_W'(RUN_LEN);
    localparam logic [RUN_W-1:0] RUN_TRIP = RUN_W'(RUN_LEN - 1);

    logic [STREAMS-1:0] lane_bad;
    logic               any_bad;
    logic               hit;
    logic [RUN_W-1:0]   run;

    // Per-lane difference between sent and returned stream.
    for (genvar g = 0; g < STREAMS; g++) begin : g_lane
        assign lane_bad[g] = tx[g] ^ rx[g];
    end

    // A compare sample counts as bad if any lane differs; it trips on the last of a run.
    always_comb begin
        any_bad = cmp_win && (|lane_bad);
        hit     = any_bad && (run >= RUN_TRIP);
    end

    // Consecutive-mismatch counter, saturating, cleared by any good or blanked sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= '0;
        end else if (any_bad) begin
            run <= (run == RUN_SAT) ? run : run + RUN_W'(1);
        end else begin
            run <= '0;
        end
    end

    // Sticky detect flag; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det <= 1'b0;
        end else if (hit) begin
            det <= 1'b1;
        end else if (clr) begin
            det <= 1'b0;
        end
    end

endmodule

// File: rtl/shield_reroute_checker.sv
// Module: shield_reroute_checker (top)
// Does: ties the mode interlock, the code/phase sequencer and the mismatch
// filter together into the shield wire-check controller.
// Assumes: rx_bits is already synchronous to clk, and the external random
// source holds a valid code on rand_code at each load edge.
module shield_reroute_checker
    import shield_reroute_pkg::*;
#(
    parameter int CODE_W       = 5,
    parameter int STREAMS      = 2,
    parameter int DEAD_CYC     = 2,
    parameter int SETTLE_CYC   = 3,
    parameter int EPOCH_CYC    = 16,
    parameter int MISMATCH_RUN = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chk_en,
    input  logic               probe_en,
    input  logic               det_clr,
    input  logic [CODE_W-1:0]  rand_code,
    input  logic [STREAMS-1:0] tx_bits,
    input  logic [STREAMS-1:0] rx_bits,
    output logic [CODE_W-1:0]  route_code,
    output logic               ph1,
    output logic               ph2,
    output logic               tamper_det,
    output logic               chk_active
);

    logic cmp_win;

    // Mode interlock: the wire check runs only while probe detection is off.
    always_comb begin
        chk_active = chk_en && !probe_en;
    end

    shield_route_sequencer #(
        .CODE_W     (CODE_W),
        .DEAD_CYC   (DEAD_CYC),
        .SETTLE_CYC (SETTLE_CYC),
        .EPOCH_CYC  (EPOCH_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (chk_active),
        .rand_code  (rand_code),
        .route_code (route_code),
        .ph1        (ph1),
        .ph2        (ph2),
        .cmp_win    (cmp_win)
    );

    shield_mismatch_filter #(
        .STREAMS (STREAMS),
        .RUN_LEN (MISMATCH_RUN)
    ) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_win (cmp_win),
        .tx      (tx_bits),
        .rx      (rx_bits),
        .clr     (det_clr),
        .det     (tamper_det)
    );

endmodule

// File: rtl/shield_reroute_checker_sva.sv
// Module: shield_reroute_checker_sva
// Does: temporal checks on the checker's ports and compare window; bound to the top.
// Assumes: rst_n is held low across at least the first clock edge.
module shield_reroute_checker_sva #(
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chk_en,
    input logic              probe_en,
    input logic              det_clr,
    input logic [CODE_W-1:0] route_code,
    input logic              ph1,
    input logic              ph2,
    input logic              tamper_det,
    input logic              cmp_win
);

    logic seen;

    // History-valid flag: set one edge after reset has been released.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    assert_phase_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph1 && ph2));

    assert_dead_before_p2_R3: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        $rose(ph2) |-> !$past(ph1));

    assert_dead_before_p1_R3: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        $rose(ph1) |-> !$past(ph2));

    assert_code_hold_R2: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (route_code != $past(route_code)) |-> (!$past(ph1) && !$past(ph2)));

    assert_interlock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_en || !chk_en) |=> (!ph1 && !ph2));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tamper_det && !det_clr) |=> tamper_det);

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (det_clr && !cmp_win) |=> !tamper_det);

    assert_blank_R5: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        $rose(tamper_det) |-> $past(cmp_win));

endmodule

bind shield_reroute_checker shield_reroute_checker_sva #(.CODE_W(CODE_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .chk_en     (chk_en),
    .probe_en   (probe_en),
    .det_clr    (det_clr),
    .route_code (route_code),
    .ph1        (ph1),
    .ph2        (ph2),
    .tamper_det (tamper_det),
    .cmp_win    (cmp_win)
);

// File: tb/shield_reroute_checker_test.sv
module shield_reroute_checker_test;

    localparam int CW     = 5;
    localparam int NS     = 2;
    localparam int DEAD   = 2;
    localparam int SETTLE = 3;
    localparam int EPOCH  = 16;
    localparam int RUN    = 2;
    localparam int PER    = DEAD + EPOCH;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chk_en = 1'b0;
    logic          probe_en = 1'b0;
    logic          det_clr = 1'b0;
    logic [CW-1:0] rand_code = '0;
    logic [NS-1:0] tx_bits = '0;
    logic [NS-1:0] rx_bits;
    logic [CW-1:0] route_code;
    logic          ph1, ph2, tamper_det, chk_active;

    logic [1:0] glitch = 2'b00;
    logic       fault_on = 1'b0;
    int         fault_j = 3;
    bit         rand_on = 1'b0;
    bit         cmp_on = 1'b0;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // reference model state
    bit          m_on = 0;
    int          m_u = 0;
    int          m_run = 0;
    bit          m_det = 0;
    logic [CW-1:0] m_code = '0;

    always #10 clk = ~clk;

    shield_reroute_checker #(
        .CODE_W(CW), .STREAMS(NS), .DEAD_CYC(DEAD), .SETTLE_CYC(SETTLE),
        .EPOCH_CYC(EPOCH), .MISMATCH_RUN(RUN)
    ) uut (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .probe_en(probe_en),
        .det_clr(det_clr), .rand_code(rand_code), .tx_bits(tx_bits),
        .rx_bits(rx_bits), .route_code(route_code), .ph1(ph1), .ph2(ph2),
        .tamper_det(tamper_det), .chk_active(chk_active)
    );

    // Shield wire model: line i carries stream code[i]; optional short of lines j, j+1.
    function automatic logic [1:0] wires(input logic [CW-1:0] code, input logic on,
                                         input logic [1:0] tx, input logic flt, input int fj);
        logic [CW-1:0] v;
        logic [1:0] r;
        logic [1:0] used;
        logic s;
        for (int i = 0; i < CW; i++) v[i] = on ? tx[code[i]] : 1'b0;
        if (flt) begin
            s = v[fj] & v[fj+1];
            v[fj] = s;
            v[fj+1] = s;
        end
        r = 2'b11;
        used = 2'b00;
        for (int i = 0; i < CW; i++) begin
            r[code[i]] = r[code[i]] & v[i];
            used[code[i]] = 1'b1;
        end
        for (int k = 0; k < 2; k++) if (!used[k]) r[k] = on ? tx[k] : 1'b0;
        return r;
    endfunction

    always @* rx_bits = wires(route_code, ph1 | ph2, tx_bits, fault_on, fault_j) ^ glitch;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Behavioural reference, updated at every clock edge.
    always @(posedge clk) begin
        bit act, cmp, mis, set;
        int q;
        cycles++;
        if (!rst_n) begin
            m_on = 0; m_u = 0; m_run = 0; m_det = 0; m_code = '0;
        end else begin
            act = chk_en && !probe_en;
            q = m_u % PER;
            cmp = act && m_on && (q >= DEAD + SETTLE);
            mis = (rx_bits !== tx_bits);
            set = 0;
            if (cmp && mis) begin
                set = (m_run >= RUN - 1);
                m_run = (m_run < RUN) ? m_run + 1 : RUN;
            end else begin
                m_run = 0;
            end
            if (set) m_det = 1;
            else if (det_clr) m_det = 0;
            if (!act) m_on = 0;
            else if (!m_on) begin m_on = 1; m_u = 0; end
            else begin
                m_u++;
                if (m_u % PER == DEAD) m_code = rand_code;
            end
        end
    end

    // Every-clock comparison of all outputs against the reference.
    always @(negedge clk) begin
        int q;
        bit on, e1, e2;
        if (cmp_on) begin
            q = m_u % PER;
            on = m_on && (q >= DEAD);
            e1 = on && ((m_u / PER) % 2 == 0);
            e2 = on && ((m_u / PER) % 2 == 1);
            check(ph1 === e1, "R3 ph1 model", ph1, e1);
            check(ph2 === e2, "R3 ph2 model", ph2, e2);
            check(route_code === m_code, "R2 code model", route_code, m_code);
            check(tamper_det === m_det, "R6 det model", tamper_det, m_det);
            check(chk_active === (chk_en && !probe_en), "R8 active", chk_active, chk_en && !probe_en);
        end
    end

    // Watchdog: a hung run is a failure and still prints the summary.
    always @(posedge clk) begin
        if (cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic cyc();
        @(negedge clk);
        if (rand_on) begin
            rand_code = CW'($urandom);
            tx_bits = NS'($urandom);
        end
    endtask

    // Wait until the next n edges are all compare samples.
    task automatic wait_window(input int n);
        int q;
        forever begin
            q = m_u % PER;
            if (m_on && q >= DEAD + SETTLE && q + n - 1 <= PER - 1) break;
            cyc();
        end
    endtask

    initial begin
        int hi, lo;
        logic [CW-1:0] sent;
        bit bad_seen;

        repeat (3) cyc();
        check(ph1 == 0 && ph2 == 0, "R1 phases", {ph1, ph2}, 0);
        check(tamper_det == 0, "R1 det", tamper_det, 0);
        check(route_code == 0, "R1 code", route_code, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        rand_on = 1'b1;
        chk_en = 1'b1;
        cyc();

        // R4/R3/R2: epoch length, dead gap, phase order and code capture.
        sent = rand_code;
        while (!(ph1 | ph2)) begin sent = rand_code; cyc(); end
        check(ph1 == 1, "R3 first epoch uses ph1", ph1, 1);
        check(route_code == sent, "R2 code captured at load", route_code, sent);
        hi = 0;
        while (ph1) begin hi++; cyc(); end
        check(hi == EPOCH, "R4 epoch length", hi, EPOCH);
        lo = 0;
        while (!(ph1 | ph2)) begin lo++; sent = rand_code; cyc(); end
        check(lo == DEAD, "R3 dead gap", lo, DEAD);
        check(ph2 == 1 && ph1 == 0, "R3 alternation to ph2", ph2, 1);
        check(route_code == sent, "R2 second code captured", route_code, sent);

        // R9: intact shield under random traffic for several periods.
        bad_seen = 0;
        repeat (6 * PER) begin cyc(); if (tamper_det) bad_seen = 1; end
        check(!bad_seen, "R9 intact shield quiet", bad_seen, 0);

        // R6: single-sample glitch is filtered.
        wait_window(2);
        glitch = 2'b01;
        cyc();
        glitch = 2'b00;
        cyc(); cyc();
        check(tamper_det == 0, "R6 single glitch ignored", tamper_det, 0);

        // R6: two consecutive mismatches on stream B trip the detect.
        wait_window(2);
        glitch = 2'b10;
        cyc(); cyc();
        glitch = 2'b00;
        check(tamper_det == 1, "R6 run trips detect", tamper_det, 1);
        cyc();
        check(tamper_det == 1, "R7 sticky", tamper_det, 1);

        // R7: clear, then set beats clear in the same cycle.
        det_clr = 1'b1;
        cyc();
        det_clr = 1'b0;
        check(tamper_det == 0, "R7 clear", tamper_det, 0);
        wait_window(3);
        glitch = 2'b01;
        cyc();
        det_clr = 1'b1;
        cyc();
        glitch = 2'b00;
        check(tamper_det == 1, "R7 set wins over clear", tamper_det, 1);
        cyc();
        det_clr = 1'b0;
        check(tamper_det == 0, "R7 clear after set", tamper_det, 0);

        // R5: mismatches in dead time and settle window are blanked.
        while (!(m_on && (m_u % PER) == 0)) cyc();
        glitch = 2'b11;
        repeat (DEAD + SETTLE) cyc();
        glitch = 2'b00;
        cyc();
        check(tamper_det == 0, "R5 blank window", tamper_det, 0);

        // R8: interlock with probe mode, mid-epoch.
        wait_window(1);
        probe_en = 1'b1;
        cyc();
        check(!ph1 && !ph2, "R8 phases drop on probe", {ph1, ph2}, 0);
        glitch = 2'b11;
        bad_seen = 0;
        repeat (30) begin cyc(); if (tamper_det || ph1 || ph2) bad_seen = 1; end
        glitch = 2'b00;
        check(!bad_seen, "R8 no check while probe on", bad_seen, 0);
        probe_en = 1'b0;
        chk_en = 1'b0;
        cyc();
        check(!ph1 && !ph2 && !chk_active, "R8 disabled", chk_active, 0);
        chk_en = 1'b1;
        lo = 0;
        while (!(ph1 | ph2)) begin lo++; cyc(); end
        check(lo == DEAD + 1, "R8 restart dead time", lo, DEAD + 1);
        check(ph1 == 1, "R8 restart on ph1", ph1, 1);

        // R9: shorted adjacent lines hidden by equal code bits, exposed by differing bits.
        rand_on = 1'b0;
        tx_bits = 2'b01;
        rand_code = 5'b11000;
        while (!((ph1 | ph2) && route_code == 5'b11000)) cyc();
        fault_on = 1'b1;
        fault_j = 3;
        det_clr = 1'b1;
        cyc();
        det_clr = 1'b0;
        bad_seen = 0;
        repeat (2 * PER) begin cyc(); if (tamper_det) bad_seen = 1; end
        check(!bad_seen, "R9 short hidden by equal bits", bad_seen, 0);
        rand_code = 5'b10000;
        repeat (2 * PER) cyc();
        check(tamper_det == 1, "R9 short exposed", tamper_det, 1);

        cmp_on = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule